// File: doc/BRIEF.md
# Quadword Memory-to-Memory DMA Channel

This block is one memory-to-memory DMA channel. Software programs it through a small register port: it writes a quadword count, a source address and a destination address, then writes the control register with the start bit set. The channel then moves the data over a request/acknowledge memory master port. Each beat reads one 128-bit quadword from the source and writes it to the destination. The destination address seen on the bus is the programmed destination register plus a fixed base (`TGT_BASE`), which places the destination inside a dedicated target region.

When the last beat finishes, the channel clears its count and its start bit. It raises a one-cycle done pulse and sets its bit in the interrupt status register, which drives the interrupt output until software clears the bit by writing a one to it. Writing the control register with the start bit clear stops the channel. An idle channel moves nothing. An active channel stops once the beat in flight has finished, keeps the count of quadwords still to move, and does not signal completion.

The sequencer has five named states:
- `ST_IDLE` goes to `ST_RD` on a start write with a nonzero count (transition *launch*), or to `ST_DONE` when the count is zero (transition *empty launch*).
- `ST_RD` goes to `ST_WR` on acknowledge (*read accepted*).
- `ST_WR` goes to `ST_STEP` on acknowledge (*write accepted*).
- `ST_STEP` decrements the count and advances both addresses by 16. From there it goes back to `ST_RD` when more quadwords remain (*next beat*), to `ST_DONE` after the last quadword (*last beat*), or to `ST_IDLE` when a stop is pending (*abort*).
- `ST_DONE` always returns to `ST_IDLE` (*retire*).

Top module: `qdma_top`

## Requirements
- R1: A transfer of count N moves exactly N quadwords (16·N bytes). It performs N read beats and N write beats, and each beat carries one 128-bit quadword.
- R2: Beat k reads the source register value plus 16·k and writes the same data to the destination register value plus 16·k plus `TGT_BASE` (default 0x5000_0000).
- R3: After each beat the source and destination registers each advance by 16. After a completed transfer they read back as their start values plus 16·N.
- R4: A write of the control register (offset 0x00) with bit 8 (start) set launches a transfer when the channel is idle. Bit 8 reads back as 1 while the transfer runs.
- R5: On completion the count register reads 0 and control bit 8 reads 0. `done_pulse` is high for exactly one cycle, 5·N cycles after the launching write's edge.
- R6: Completion sets bit 2 of the status register (offset 0x40), and `dma_irq` follows that bit. Writing a 1 to bit 2 clears it, and writing a 0 there leaves it unchanged.
- R7: A launch with a count of 0 makes no memory access and raises `done_pulse` in the cycle after the launching edge, with status bit 2 set.
- R8: A control write with bit 8 clear while the channel is idle makes no memory access and raises no done pulse.
- R9: A control write with bit 8 clear during a transfer finishes the beat in flight and then returns the channel to idle. The count then holds the number of quadwords not yet moved, no done pulse appears, and the status bit stays clear.
- R10: While a transfer runs, writes to the count (0x10), source (0x20) and destination (0x30) registers are ignored.
- R11: Registers sit in 16-byte slots selected by address bits [7:4]. Only an address with bits [3:0] equal to zero decodes. All registers reset to 0.
- R12: Once `mem_req` is raised, it stays high with a stable address and write flag until `mem_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_we | input | 1 | Register write strobe |
| cpu_addr | input | 8 | Register byte offset |
| cpu_wdata | input | 32 | Register write data |
| cpu_rdata | output | 32 | Register read data for `cpu_addr` (combinational) |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write beat, 0 = read beat |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 128 | Write quadword |
| mem_rdata | input | 128 | Read quadword, valid with `mem_ack` on a read |
| mem_ack | input | 1 | Memory acknowledge |
| done_pulse | output | 1 | One-cycle completion pulse |
| dma_irq | output | 1 | Channel interrupt (status bit 2) |

## Verification
A register write takes effect at the clock edge where it is sampled. The first read request appears in the cycle after that edge. With the bench's memory acknowledging one cycle after each request, every beat takes five cycles: two in read, two in write and one in step. The done pulse therefore falls exactly 5·N cycles after the launching edge, or one cycle after it when N is 0. The cleared count, the cleared start bit, the stepped addresses and the interrupt are visible one cycle after the pulse. The bench drives and samples on the falling edge and waits exactly these cycle counts before each comparison. It checks the pulse at its due cycle and also checks that the pulse is absent one cycle earlier.

// File: rtl/qdma_pkg.sv
package qdma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_WR,
        ST_STEP,
        ST_DONE
    } qdma_state_t;

    localparam int SLOT_CTRL = 0;
    localparam int SLOT_QWC  = 1;
    localparam int SLOT_SRC  = 2;
    localparam int SLOT_DST  = 3;
    localparam int SLOT_STAT = 4;

    localparam int START_BIT = 8;
    localparam int QW_BYTES  = 16;

endpackage

// File: rtl/qdma_regs.sv
module qdma_regs
    import qdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int QWC_W  = 16,
    parameter int CPU_AW = 8,
    parameter int CPU_DW = 32,
    parameter int CH_BIT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_we,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic [CPU_DW-1:0] cpu_wdata,
    output logic [CPU_DW-1:0] cpu_rdata,
    input  logic              busy,
    input  logic              beat_done,
    input  logic              finish,
    output logic              launch,
    output logic              stop_wr,
    output logic              start_bit,
    output logic [QWC_W-1:0]  qwc,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr,
    output logic              irq
);

    localparam int SLOT_W = CPU_AW - 4;
    localparam logic [ADDR_W-1:0] ADDR_STEP = ADDR_W'(QW_BYTES);

    logic [CPU_DW-1:0] ctrl_q;
    logic              stat_q;
    logic [SLOT_W-1:0] slot;
    logic              aligned;
    logic              hit_ctrl, hit_qwc, hit_src, hit_dst, hit_stat;

    assign slot     = cpu_addr[CPU_AW-1:4];
    assign aligned  = (cpu_addr[3:0] == 4'd0);
    assign hit_ctrl = cpu_we && aligned && (slot == SLOT_W'(SLOT_CTRL));
    assign hit_qwc  = cpu_we && aligned && (slot == SLOT_W'(SLOT_QWC));
    assign hit_src  = cpu_we && aligned && (slot == SLOT_W'(SLOT_SRC));
    assign hit_dst  = cpu_we && aligned && (slot == SLOT_W'(SLOT_DST));
    assign hit_stat = cpu_we && aligned && (slot == SLOT_W'(SLOT_STAT));

    assign launch    = hit_ctrl && cpu_wdata[START_BIT] && !busy;
    assign stop_wr   = hit_ctrl && !cpu_wdata[START_BIT] && busy;
    assign start_bit = ctrl_q[START_BIT];
    assign irq       = stat_q;

    // Control register: free-form bits are taken only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (finish) begin
            ctrl_q[START_BIT] <= 1'b0;
        end else if (hit_ctrl) begin
            if (!busy) begin
                ctrl_q <= cpu_wdata;
            end else if (!cpu_wdata[START_BIT]) begin
                ctrl_q[START_BIT] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            qwc <= '0;
        end else if (finish) begin
            qwc <= '0;
        end else if (beat_done) begin
            qwc <= qwc - QWC_W'(1);
        end else if (hit_qwc && !busy) begin
            qwc <= cpu_wdata[QWC_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_addr <= '0;
            dst_addr <= '0;
        end else if (beat_done) begin
            src_addr <= src_addr + ADDR_STEP;
            dst_addr <= dst_addr + ADDR_STEP;
        end else begin
            if (hit_src && !busy) begin
                src_addr <= cpu_wdata[ADDR_W-1:0];
            end
            if (hit_dst && !busy) begin
                dst_addr <= cpu_wdata[ADDR_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= 1'b0;
        end else if (finish) begin
            stat_q <= 1'b1;
        end else if (hit_stat && cpu_wdata[CH_BIT]) begin
            stat_q <= 1'b0;
        end
    end

    always_comb begin
        cpu_rdata = '0;
        if (aligned) begin
            unique case (slot)
                SLOT_W'(SLOT_CTRL): cpu_rdata = ctrl_q;
                SLOT_W'(SLOT_QWC):  cpu_rdata = CPU_DW'(qwc);
                SLOT_W'(SLOT_SRC):  cpu_rdata = CPU_DW'(src_addr);
                SLOT_W'(SLOT_DST):  cpu_rdata = CPU_DW'(dst_addr);
                SLOT_W'(SLOT_STAT): cpu_rdata[CH_BIT] = stat_q;
                default:            cpu_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/qdma_seq.sv
module qdma_seq
    import qdma_pkg::*;
#(
    parameter int QWC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  logic             stop_wr,
    input  logic [QWC_W-1:0] qwc,
    input  logic             mem_ack,
    output qdma_state_t      state,
    output logic             busy,
    output logic             mem_req,
    output logic             mem_we,
    output logic             rd_take,
    output logic             beat_done,
    output logic             finish
);

    qdma_state_t state_d;
    logic        stop_pend;
    logic        stop_now;
    logic        qwc_zero;
    logic        qwc_last;

    assign qwc_zero = (qwc == '0);
    assign qwc_last = (qwc == QWC_W'(1));
    assign stop_now = stop_pend || stop_wr;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_d;
        end
    end

    // Stop requests are held until the beat in flight reaches the step state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stop_pend <= 1'b0;
        end else if (state == ST_RD || state == ST_WR) begin
            stop_pend <= stop_pend || stop_wr;
        end else begin
            stop_pend <= 1'b0;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE: begin
                if (launch) begin
                    state_d = qwc_zero ? ST_DONE : ST_RD;
                end
            end
            ST_RD: begin
                if (mem_ack) begin
                    state_d = ST_WR;
                end
            end
            ST_WR: begin
                if (mem_ack) begin
                    state_d = ST_STEP;
                end
            end
            ST_STEP: begin
                if (stop_now) begin
                    state_d = ST_IDLE;
                end else if (qwc_last) begin
                    state_d = ST_DONE;
                end else begin
                    state_d = ST_RD;
                end
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs decoded from the current state.
    always_comb begin
        busy      = 1'b1;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        rd_take   = 1'b0;
        beat_done = 1'b0;
        finish    = 1'b0;
        unique case (state)
            ST_IDLE: busy = 1'b0;
            ST_RD: begin
                mem_req = 1'b1;
                rd_take = mem_ack;
            end
            ST_WR: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
            end
            ST_STEP: beat_done = 1'b1;
            ST_DONE: finish    = 1'b1;
            default: busy      = 1'b0;
        endcase
    end

endmodule

// File: rtl/qdma_path.sv
module qdma_path #(
    parameter int              ADDR_W   = 32,
    parameter int              DATA_W   = 128,
    parameter logic [ADDR_W-1:0] TGT_BASE = 32'h5000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mem_we,
    input  logic              rd_take,
    input  logic [ADDR_W-1:0] src_addr,
    input  logic [ADDR_W-1:0] dst_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata
);

    logic [DATA_W-1:0] beat_q;

    // Holds the quadword between the read beat and the write beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_q <= '0;
        end else if (rd_take) begin
            beat_q <= mem_rdata;
        end
    end

    assign mem_addr  = mem_we ? (dst_addr + TGT_BASE) : src_addr;
    assign mem_wdata = beat_q;

endmodule

// File: rtl/qdma_top.sv
module qdma_top
    import qdma_pkg::*;
#(
    parameter int                ADDR_W   = 32,
    parameter int                DATA_W   = 128,
    parameter int                QWC_W    = 16,
    parameter int                CPU_AW   = 8,
    parameter int                CPU_DW   = 32,
    parameter int                CH_BIT   = 2,
    parameter logic [ADDR_W-1:0] TGT_BASE = 32'h5000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_we,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic [CPU_DW-1:0] cpu_wdata,
    output logic [CPU_DW-1:0] cpu_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic              done_pulse,
    output logic              dma_irq
);

    qdma_state_t       state;
    logic              busy, launch, stop_wr, start_bit;
    logic              rd_take, beat_done, finish;
    logic [QWC_W-1:0]  qwc;
    logic [ADDR_W-1:0] src_addr, dst_addr;

    qdma_regs #(
        .ADDR_W (ADDR_W),
        .QWC_W  (QWC_W),
        .CPU_AW (CPU_AW),
        .CPU_DW (CPU_DW),
        .CH_BIT (CH_BIT)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_we    (cpu_we),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_rdata (cpu_rdata),
        .busy      (busy),
        .beat_done (beat_done),
        .finish    (finish),
        .launch    (launch),
        .stop_wr   (stop_wr),
        .start_bit (start_bit),
        .qwc       (qwc),
        .src_addr  (src_addr),
        .dst_addr  (dst_addr),
        .irq       (dma_irq)
    );

    qdma_seq #(
        .QWC_W (QWC_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .stop_wr   (stop_wr),
        .qwc       (qwc),
        .mem_ack   (mem_ack),
        .state     (state),
        .busy      (busy),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .rd_take   (rd_take),
        .beat_done (beat_done),
        .finish    (finish)
    );

    qdma_path #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .TGT_BASE (TGT_BASE)
    ) u_path (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_we    (mem_we),
        .rd_take   (rd_take),
        .src_addr  (src_addr),
        .dst_addr  (dst_addr),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

    assign done_pulse = finish;

endmodule

// File: rtl/qdma_checker.sv
module qdma_checker #(
    parameter int ADDR_W = 32,
    parameter int QWC_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              done_pulse,
    input logic              dma_irq,
    input logic              start_bit,
    input logic              launch,
    input logic              beat_done,
    input logic              busy,
    input logic              cpu_we,
    input logic [7:0]        cpu_addr,
    input logic [QWC_W-1:0]  qwc,
    input logic [ADDR_W-1:0] src_addr,
    input logic [ADDR_W-1:0] dst_addr
);

    assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse);

    assert_done_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> (qwc == '0 && !start_bit));

    assert_irq_on_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> dma_irq);

    assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        beat_done |=> (src_addr == $past(src_addr) + ADDR_W'(16)
                       && dst_addr == $past(dst_addr) + ADDR_W'(16)));

    assert_busy_src_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !beat_done && cpu_we && cpu_addr == 8'h20) |=> $stable(src_addr));

    assert_zero_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && qwc == '0) |=> done_pulse);

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !launch) |=> !mem_req);

endmodule

bind qdma_top qdma_checker #(
    .ADDR_W (ADDR_W),
    .QWC_W  (QWC_W)
) u_qdma_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_ack    (mem_ack),
    .mem_addr   (mem_addr),
    .done_pulse (done_pulse),
    .dma_irq    (dma_irq),
    .start_bit  (start_bit),
    .launch     (launch),
    .beat_done  (beat_done),
    .busy       (busy),
    .cpu_we     (cpu_we),
    .cpu_addr   (cpu_addr),
    .qwc        (qwc),
    .src_addr   (src_addr),
    .dst_addr   (dst_addr)
);

// File: tb/qdma_top_bench.sv
module qdma_top_bench;

    localparam logic [31:0] TGT = 32'h5000_0000;
    localparam int NV = 3;
    localparam logic [31:0] V_N   [NV] = '{32'd1, 32'd2, 32'd5};
    localparam logic [31:0] V_SRC [NV] = '{32'h000, 32'h100, 32'h200};
    localparam logic [31:0] V_DST [NV] = '{32'h000, 32'h040, 32'h100};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cpu_we = 1'b0;
    logic [7:0]   cpu_addr = 8'h0;
    logic [31:0]  cpu_wdata = 32'h0;
    logic [31:0]  cpu_rdata;
    logic         mem_req, mem_we, mem_ack;
    logic [31:0]  mem_addr;
    logic [127:0] mem_wdata, mem_rdata;
    logic         done_pulse, dma_irq;

    int checks = 0;
    int errors = 0;
    int rd_beats = 0;
    int wr_beats = 0;
    int done_cnt = 0;
    bit finished = 0;

    logic [127:0] srcm [64];
    logic [127:0] dstm [64];

    always #10 clk = ~clk;

    qdma_top u_qdma_top (
        .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack), .done_pulse(done_pulse),
        .dma_irq(dma_irq)
    );

    function automatic logic [127:0] sdat(int i);
        return {4{32'hC0DE_0000 | 32'(i)}};
    endfunction

    initial begin
        for (int i = 0; i < 64; i++) srcm[i] = sdat(i);
    end

    // Memory model: acknowledges one cycle after each request.
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack   <= 1'b0;
            mem_rdata <= '0;
        end else if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) begin
                if (mem_addr[31:28] == TGT[31:28]) dstm[mem_addr[9:4]] <= mem_wdata;
                wr_beats = wr_beats + 1;
            end else begin
                mem_rdata <= srcm[mem_addr[9:4]];
                rd_beats = rd_beats + 1;
            end
        end else begin
            mem_ack <= 1'b0;
        end
    end

    always @(posedge clk) if (rst_n && done_pulse) done_cnt = done_cnt + 1;

    task automatic check(string req, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_we = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        cpu_addr = a;
        #1;
        d = cpu_rdata;
    endtask

    task automatic tick(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        logic [31:0] v;
        int rb, wb, dc, n;
        tick(4);
        rst_n = 1'b1;
        tick(1);

        // R11: reset values
        rd(8'h00, v); check("R11 ctrl reset", v, 0);
        rd(8'h10, v); check("R11 qwc reset", v, 0);
        rd(8'h20, v); check("R11 src reset", v, 0);
        rd(8'h40, v); check("R11 stat reset", v, 0);
        check("R11 outputs idle", {mem_req, done_pulse, dma_irq}, 0);

        // Table of transfers: R1 R2 R3 R4 R5 R6
        for (int t = 0; t < NV; t++) begin
            n = int'(V_N[t]);
            rb = rd_beats; wb = wr_beats; dc = done_cnt;
            wr(8'h10, V_N[t]);
            wr(8'h20, V_SRC[t]);
            wr(8'h30, V_DST[t]);
            wr(8'h00, 32'h0000_0100);
            rd(8'h00, v); check("R4 start reads 1", v[8], 1);
            tick(5 * n - 1);
            check("R5 no early done", done_pulse, 0);
            tick(1);
            check("R5 done due", done_pulse, 1);
            tick(1);
            check("R5 one-cycle pulse", done_pulse, 0);
            rd(8'h10, v); check("R5 count cleared", v, 0);
            rd(8'h00, v); check("R5 start cleared", v[8], 0);
            check("R6 irq set", dma_irq, 1);
            rd(8'h40, v); check("R6 status bit2", v, 32'h4);
            rd(8'h20, v); check("R3 src end", v, V_SRC[t] + 32'(16 * n));
            rd(8'h30, v); check("R3 dst end", v, V_DST[t] + 32'(16 * n));
            check("R1 read beats", 32'(rd_beats - rb), 32'(n));
            check("R1 write beats", 32'(wr_beats - wb), 32'(n));
            check("R5 single done", 32'(done_cnt - dc), 1);
            for (int k = 0; k < n; k++)
                check("R2 target data", dstm[int'(V_DST[t][9:4]) + k],
                      sdat(int'(V_SRC[t][9:4]) + k));
            wr(8'h40, 32'h0);
            check("R6 write 0 keeps", dma_irq, 1);
            wr(8'h40, 32'h4);
            check("R6 w1c clears", dma_irq, 0);
        end

        // R7: zero-count launch
        rb = rd_beats; wb = wr_beats;
        wr(8'h10, 32'h0);
        wr(8'h00, 32'h0000_0100);
        check("R7 immediate done", done_pulse, 1);
        tick(1);
        check("R7 irq", dma_irq, 1);
        check("R7 no traffic", 32'(rd_beats - rb + wr_beats - wb), 0);
        wr(8'h40, 32'h4);

        // R8: stop while idle
        rb = rd_beats; wb = wr_beats; dc = done_cnt;
        wr(8'h10, 32'h3);
        wr(8'h00, 32'h0);
        tick(8);
        check("R8 no traffic", 32'(rd_beats - rb + wr_beats - wb), 0);
        check("R8 no done", 32'(done_cnt - dc), 0);

        // R10: writes ignored while active
        wr(8'h10, 32'h2);
        wr(8'h20, 32'h040);
        wr(8'h30, 32'h300);
        wr(8'h00, 32'h0000_0100);
        wr(8'h10, 32'h9);
        wr(8'h20, 32'h3F0);
        wr(8'h30, 32'h3F0);
        tick(7);
        check("R10 done on time", done_pulse, 1);
        tick(1);
        rd(8'h20, v); check("R10 src kept", v, 32'h060);
        rd(8'h30, v); check("R10 dst kept", v, 32'h320);
        check("R10 data0", dstm[48], sdat(4));
        check("R10 data1", dstm[49], sdat(5));
        wr(8'h40, 32'h4);

        // R9: stop during a transfer
        rb = rd_beats; wb = wr_beats; dc = done_cnt;
        wr(8'h10, 32'h4);
        wr(8'h20, 32'h000);
        wr(8'h30, 32'h380);
        wr(8'h00, 32'h0000_0100);
        tick(1);
        wr(8'h00, 32'h0);
        tick(4);
        rd(8'h10, v); check("R9 remaining count", v, 32'h3);
        check("R9 one beat", 32'(wr_beats - wb), 1);
        check("R9 no done", 32'(done_cnt - dc), 0);
        check("R9 irq clear", dma_irq, 0);
        check("R9 idle", mem_req, 0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule